// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues clause-22 style management transactions to an Ethernet PHY over a two-wire management link. The host pulses a start strobe with a read/write select, a 5-bit register number and 16 bits of write data. The block then clocks out one complete frame on MDC, drives the shared MDIO line through an output value and an output enable, and for reads collects 16 bits from the PHY. The PHY address field is always zero.

MDC is derived from the system clock. Each MDC half-period lasts `MDC_HALF` system clocks, a parameter. A frame always spans exactly 64 MDC cycles. These are the 32-cycle all-ones preamble, start and opcode pairs, the zero PHY address, the register number, turnaround, and the data field. On a read the field after a single turnaround cycle is captured, and one extra undriven cycle closes the frame. On a write two undriven turnaround cycles come first, and the data is then driven to the end. Outside a frame MDC is low and MDIO is released. The host sees `busy` for the whole frame and a one-cycle `done` at its end, when read data becomes valid.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, and whenever no frame is running, mdc_o, mdio_o, mdio_oe, busy_o and done_o are 0. After reset rdata_o is 0.
- R2: A start accepted at a clock edge makes busy_o high from that edge for exactly 128*MDC_HALF system clocks. Each MDC high or low phase lasts MDC_HALF clocks, and a frame contains exactly 64 MDC rising edges.
- R3: In MDC cycles 0 to 31 (counted from 0 at the first rising edge) mdio_oe is 1 and mdio_o is 1.
- R4: Cycles 32 and 33 carry 0 then 1. Cycles 34 and 35 carry 1,0 when rd_sel_i was 1 (read) and 0,1 when it was 0 (write). mdio_oe is 1 in all four.
- R5: Cycles 36 to 40 drive 0 with mdio_oe 1. Cycles 41 to 45 drive reg_i bit 4 down to bit 0, with mdio_oe 1.
- R6: On a read, mdio_oe is 0 in cycles 46 to 63. The values on mdio_i in cycles 47 to 62 are captured MSB first, each sampled at the last system clock of the MDC high phase. The captured word appears on rdata_o together with done_o.
- R7: On a write, mdio_oe is 0 in cycles 46 and 47. Cycles 48 to 63 drive wdata_i bit 15 down to bit 0 with mdio_oe 1.
- R8: mdio_o and mdio_oe do not change while MDC stays high. Whenever mdio_oe is 0, mdio_o is 0.
- R9: done_o is a single-cycle pulse, raised in the first clock after the last MDC high phase, and busy_o is 0 in that cycle.
- R10: The start strobe is ignored while busy_o is 1. The command fields are taken at the accepting edge, so later changes on rd_sel_i, reg_i or wdata_i do not alter the running frame.
- R11: On a read, mdio_i values outside cycles 47 to 62 do not affect rdata_o. A write frame leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when idle |
| rd_sel_i | input | 1 | 1 = read frame, 0 = write frame |
| reg_i | input | 5 | PHY register number |
| wdata_i | input | 16 | Data for write frames |
| mdio_i | input | 1 | MDIO line value from the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO pad output enable |
| rdata_o | output | 16 | Last read result |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A corrupted slot counter shows up at once as a field bit sitting in the wrong MDC cycle. It also shows up at the end of the frame as a rising-edge count other than 64 or a busy window of the wrong length. A wrong phase or divider count lengthens or shortens MDC phases within the first few system clocks, and it can also show as a change of MDIO while MDC is high. Errors in capture or command latching appear only when done rises, as a wrong read word, or as field bits that follow inputs changed mid-frame.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    localparam int SLOT_W = 6;
    localparam int DATA_W = 16;
    localparam int REG_W  = 5;

    localparam logic [SLOT_W-1:0] SL_PRE_END   = 6'd31;
    localparam logic [SLOT_W-1:0] SL_ST_ZERO   = 6'd32;
    localparam logic [SLOT_W-1:0] SL_ST_ONE    = 6'd33;
    localparam logic [SLOT_W-1:0] SL_OP_A      = 6'd34;
    localparam logic [SLOT_W-1:0] SL_OP_B      = 6'd35;
    localparam logic [SLOT_W-1:0] SL_ADDR_END  = 6'd40;
    localparam logic [SLOT_W-1:0] SL_REG_END   = 6'd45;
    localparam logic [SLOT_W-1:0] SL_TA_FIRST  = 6'd46;
    localparam logic [SLOT_W-1:0] SL_RD_FIRST  = 6'd47;
    localparam logic [SLOT_W-1:0] SL_RD_LAST   = 6'd62;
    localparam logic [SLOT_W-1:0] SL_WR_FIRST  = 6'd48;
    localparam logic [SLOT_W-1:0] SL_LAST      = 6'd63;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [SLOT_W-1:0]   slot;
        logic                rd;
        logic [REG_W-1:0]    regn;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   shift;
        logic [DATA_W-1:0]   rdata;
        logic                done;
    } mfm_state_t;

endpackage

// File: rtl/mfm_divider.sv
module mfm_divider #(
    parameter int MDC_HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MDC_HALF - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             tick;

    always_comb begin
        tick  = run_i && (cnt_q == CNT_LAST);
        cnt_d = cnt_q;
        if (!run_i || tick) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = tick;

    generate
        if (MDC_HALF > 1) begin : g_spacing
            // R2: a phase never ends on two consecutive clocks
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/mfm_slot_map.sv
module mfm_slot_map
    import mfm_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  regn_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              drv_o,
    output logic              oe_o,
    output logic              cap_o
);
    logic [SLOT_W-1:0] reg_idx;
    logic [SLOT_W-1:0] dat_idx;

    always_comb begin
        reg_idx = SL_REG_END - slot_i;
        dat_idx = SL_LAST - slot_i;
        drv_o   = 1'b0;
        oe_o    = 1'b0;
        cap_o   = 1'b0;
        if (slot_i <= SL_PRE_END) begin
            oe_o  = 1'b1;
            drv_o = 1'b1;
        end else if (slot_i == SL_ST_ZERO) begin
            oe_o  = 1'b1;
        end else if (slot_i == SL_ST_ONE) begin
            oe_o  = 1'b1;
            drv_o = 1'b1;
        end else if (slot_i == SL_OP_A) begin
            oe_o  = 1'b1;
            drv_o = rd_i;
        end else if (slot_i == SL_OP_B) begin
            oe_o  = 1'b1;
            drv_o = !rd_i;
        end else if (slot_i <= SL_ADDR_END) begin
            oe_o  = 1'b1;
        end else if (slot_i <= SL_REG_END) begin
            oe_o  = 1'b1;
            drv_o = regn_i[reg_idx[2:0]];
        end else if (rd_i) begin
            cap_o = (slot_i >= SL_RD_FIRST) && (slot_i <= SL_RD_LAST);
        end else if (slot_i >= SL_WR_FIRST) begin
            oe_o  = 1'b1;
            drv_o = wdata_i[dat_idx[3:0]];
        end
    end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mfm_pkg::*;
#(
    parameter int MDC_HALF = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_sel_i,
    input  logic [4:0]  reg_i,
    input  logic [15:0] wdata_i,
    input  logic        mdio_i,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rdata_o,
    output logic        busy_o,
    output logic        done_o
);
    mfm_state_t s_d, s_q;
    logic       tick;
    logic       run;
    logic       map_drv, map_oe, map_cap;

    assign run = (s_q.phase != PH_IDLE);

    mfm_divider #(.MDC_HALF(MDC_HALF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    mfm_slot_map u_map (
        .slot_i  (s_q.slot),
        .rd_i    (s_q.rd),
        .regn_i  (s_q.regn),
        .wdata_i (s_q.wdata),
        .drv_o   (map_drv),
        .oe_o    (map_oe),
        .cap_o   (map_cap)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_LOW;
                    s_d.slot  = '0;
                    s_d.rd    = rd_sel_i;
                    s_d.regn  = reg_i;
                    s_d.wdata = wdata_i;
                    s_d.shift = '0;
                end
            end
            PH_LOW: begin
                if (tick) s_d.phase = PH_HIGH;
            end
            PH_HIGH: begin
                if (tick) begin
                    if (map_cap) s_d.shift = {s_q.shift[DATA_W-2:0], mdio_i};
                    if (s_q.slot == SL_LAST) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                        if (s_q.rd) s_d.rdata = s_q.shift;
                    end else begin
                        s_d.slot  = s_q.slot + 1'b1;
                        s_d.phase = PH_LOW;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc_o   = (s_q.phase == PH_HIGH);
    assign mdio_oe = run && map_oe;
    assign mdio_o  = run && map_oe && map_drv;
    assign rdata_o = s_q.rdata;
    assign busy_o  = run;
    assign done_o  = s_q.done;

    // R1: released and quiet whenever no frame runs
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_o && !mdio_oe));

    // R8: pad outputs hold across an MDC high phase
    p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: nothing driven without the enable
    p_no_drive_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> !mdio_o);

    // R9: single-cycle done with busy already low
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10: command fields frozen for the whole frame
    p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(s_q.rd) && $stable(s_q.regn) && $stable(s_q.wdata)));

    // R6: turnaround cycle of a read leaves the line released
    p_ta_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.rd && s_q.slot >= SL_TA_FIRST) |-> !mdio_oe);

    // R11: read data only moves at the end of a read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && s_q.rd) |-> (rdata_o == $past(rdata_o)) || $past(!rst_n));

endmodule

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_sel_i = 1'b0;
    logic [4:0]  reg_i = '0;
    logic [15:0] wdata_i = '0;
    logic        mdio_i = 1'b1;
    logic        mdc_o, mdio_o, mdio_oe, busy_o, done_o;
    logic [15:0] rdata_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_frame_master #(.MDC_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_sel_i(rd_sel_i),
        .reg_i(reg_i), .wdata_i(wdata_i), .mdio_i(mdio_i), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata_o(rdata_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // Monitor and PHY model, all at the falling system clock edge
    logic        obs_oe [64];
    logic        obs_do [64];
    logic        exp_oe [64];
    logic        exp_do [64];
    int          mon_slot = 0;
    int          hold_err = 0;
    int          ph_hi = 0, ph_lo = 0, ph_err = 0;
    logic        prev_mdc = 1'b0;
    logic        phy_rd = 1'b0;
    logic [15:0] phy_resp = '0;
    logic        phy_noise = 1'b1;

    always @(negedge clk) begin
        if (mdc_o && !prev_mdc) begin
            if (mon_slot < 64) begin
                obs_oe[mon_slot] = mdio_oe;
                obs_do[mon_slot] = mdio_o;
            end
            mon_slot = mon_slot + 1;
            if (mon_slot > 1 && ph_lo != HALF) ph_err = ph_err + 1;
            ph_hi = 1;
        end else if (mdc_o && prev_mdc) begin
            ph_hi = ph_hi + 1;
            if (mon_slot >= 1 && mon_slot <= 64)
                if (mdio_oe !== obs_oe[mon_slot-1] || mdio_o !== obs_do[mon_slot-1])
                    hold_err = hold_err + 1;
        end else if (!mdc_o && prev_mdc) begin
            if (ph_hi != HALF) ph_err = ph_err + 1;
            ph_lo = 0;
            if (phy_rd && mon_slot >= 47 && mon_slot <= 62) mdio_i = phy_resp[62 - mon_slot];
            else                                             mdio_i = phy_noise;
        end
        if (!mdc_o && busy_o) ph_lo = ph_lo + 1;
        if (!mdio_oe && mdio_o) hold_err = hold_err + 1;
        prev_mdc = mdc_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_exp(input logic rd, input logic [4:0] rg, input logic [15:0] wd);
        for (int s = 0; s < 64; s++) begin
            exp_oe[s] = 1'b1;
            exp_do[s] = 1'b0;
            if (s < 32) exp_do[s] = 1'b1;
            else if (s == 33) exp_do[s] = 1'b1;
            else if (s == 34) exp_do[s] = rd;
            else if (s == 35) exp_do[s] = ~rd;
            else if (s >= 41 && s <= 45) exp_do[s] = rg[45 - s];
            else if (s >= 46) begin
                if (rd || s < 48) exp_oe[s] = 1'b0;
                else exp_do[s] = wd[63 - s];
            end
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int bad = 0;
        int first = -1;
        for (int s = lo; s <= hi; s++)
            if (obs_oe[s] !== exp_oe[s] || obs_do[s] !== exp_do[s]) begin
                bad = bad + 1;
                if (first < 0) first = s;
            end
        chk(bad == 0, tag, (first < 0) ? 0 : {obs_oe[first], obs_do[first]},
            (first < 0) ? 0 : {exp_oe[first], exp_do[first]});
    endtask

    task automatic run_frame(input logic rd, input logic [4:0] rg, input logic [15:0] wd,
                             input logic [15:0] resp, input logic noise, input bit disturb);
        int busy_cyc = 0;
        int guard = 0;
        build_exp(rd, rg, wd);
        phy_rd = rd; phy_resp = resp; phy_noise = noise; mdio_i = noise;
        mon_slot = 0; hold_err = 0; ph_err = 0;
        @(negedge clk);
        start_i = 1'b1; rd_sel_i = rd; reg_i = rg; wdata_i = wd;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && guard < 5000) begin
            if (busy_o) busy_cyc = busy_cyc + 1;
            if (disturb && guard == 50) begin
                start_i = 1'b1; rd_sel_i = ~rd; reg_i = ~rg; wdata_i = ~wd;
            end
            if (disturb && guard == 51) start_i = 1'b0;
            @(negedge clk);
            guard = guard + 1;
        end
        chk(busy_cyc == 128 * HALF, "R2 busy length", busy_cyc, 128 * HALF);
        chk(mon_slot == 64, "R2 mdc rising edges", mon_slot, 64);
        chk(ph_err == 0, "R2 mdc phase length", ph_err, 0);
        chk(done_o && !busy_o, "R9 done with busy low", {done_o, busy_o}, 2'b10);
        cmp_range(0, 31, "R3 preamble");
        cmp_range(32, 35, "R4 start and opcode");
        cmp_range(36, 45, "R5 address and register");
        cmp_range(46, 63, rd ? "R6 read turnaround and data release" : "R7 write turnaround and data");
        chk(hold_err == 0, "R8 output hold while mdc high", hold_err, 0);
        @(negedge clk);
        chk(!done_o, "R9 done single cycle", done_o, 0);
    endtask

    task automatic t_reset;
        chk(!mdc_o && !mdio_o && !mdio_oe, "R1 pad idle after reset", {mdc_o, mdio_o, mdio_oe}, 0);
        chk(!busy_o && !done_o, "R1 status idle after reset", {busy_o, done_o}, 0);
        chk(rdata_o == 16'h0, "R1 rdata after reset", rdata_o, 0);
    endtask

    task automatic t_read_basic;
        run_frame(1'b1, 5'b10110, 16'hFFFF, 16'hA5C3, 1'b1, 1'b0);
        chk(rdata_o == 16'hA5C3, "R6 read capture", rdata_o, 16'hA5C3);
        run_frame(1'b1, 5'b00001, 16'h0000, 16'h8001, 1'b0, 1'b0);
        chk(rdata_o == 16'h8001, "R6 read capture msb/lsb", rdata_o, 16'h8001);
    endtask

    task automatic t_read_noise;
        run_frame(1'b1, 5'b11111, 16'h0000, 16'h0000, 1'b1, 1'b0);
        chk(rdata_o == 16'h0000, "R11 mdio outside window ignored", rdata_o, 0);
    endtask

    task automatic t_write;
        run_frame(1'b0, 5'b01001, 16'h3C96, 16'hFFFF, 1'b1, 1'b0);
        chk(rdata_o == 16'h0000, "R11 write leaves rdata", rdata_o, 0);
        run_frame(1'b0, 5'b10000, 16'h8001, 16'h0000, 1'b0, 1'b0);
        chk(!mdc_o && !mdio_o && !mdio_oe && !busy_o, "R1 pad idle after frame",
            {mdc_o, mdio_o, mdio_oe, busy_o}, 0);
    endtask

    task automatic t_busy_ignore;
        run_frame(1'b1, 5'b00101, 16'h1234, 16'h5A0F, 1'b1, 1'b1);
        chk(rdata_o == 16'h5A0F, "R10 frame unaffected by mid-frame inputs", rdata_o, 16'h5A0F);
        mon_slot = 0;
        repeat (400) @(negedge clk);
        chk(!busy_o && mon_slot == 0, "R10 start during busy ignored", {busy_o, mon_slot[7:0]}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_read_basic;
        t_read_noise;
        t_write;
        t_busy_ignore;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule